// File: doc/BRIEF.md
# Byte-Lane Data Steering for a Split-Lane 8/16-bit Bus

This block sits between a system bus and a byte-addressed memory built as two 8-bit banks. The bus has two 8-bit data lanes. In an 8-bit transfer, one lane (lane A) carries write data from the master and the other lane (lane B) carries read data back to it. In a 16-bit transfer, the two lanes work together as one bidirectional 16-bit path. The master flags the width of every transfer, so the steering is decided again on each cycle.

On every clock edge where a cycle is presented, the block decodes the width, the direction, address bit 0 and the active-low phantom input. From these it registers the bank write strobes, the bank write data, the bank word address and the lane driver enables. Read data from the banks passes through a lane multiplexer that uses the registered selection, so bus drive follows the selection in the same cycle as the bank address. The memory covers the whole 24-bit space. It has no start-address decode.

Top module: `data_steer`

## Requirements
- R1: While reset is held low, and in the first cycle after it, both bank write strobes and both lane enables are low.
- R2: An 8-bit write (wide_i=0) at an even address (addr_i[0]=0) asserts only bank_lo_we_o, one cycle after the sampling edge, with bank_lo_wdata_o equal to the lane A input.
- R3: An 8-bit write at an odd address (addr_i[0]=1) asserts only bank_hi_we_o, with bank_hi_wdata_o equal to the lane A input. The lane B input is not used.
- R4: An 8-bit read enables only lane B. Lane B carries the high bank when addr_i[0]=1 and the low bank when addr_i[0]=0. Lane A is not driven.
- R5: A 16-bit write (wide_i=1) asserts both bank strobes together. The low bank takes the lane A input and the high bank takes the lane B input.
- R6: A 16-bit read enables both lanes. Lane A carries the low bank and lane B carries the high bank. Lane A is never enabled without lane B.
- R7: In a 16-bit transfer, address bit 0 is ignored. An odd address steers exactly like the even address below it.
- R8: A cycle sampled with phantom_ni low gives no write strobe and no lane enable.
- R9: bank_addr_o carries addr_i[23:1] of the sampled cycle for any address in the full 24-bit range.
- R10: Steering is decided again for every cycle. Back-to-back cycles of different width each steer by their own flag, and an edge with no cycle presented gives no strobe and no enable.
- R11: A lane whose enable is low outputs all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | A bus cycle is presented this edge |
| rd_i | input | 1 | Cycle is a read |
| wr_i | input | 1 | Cycle is a write |
| wide_i | input | 1 | 1: 16-bit transfer, 0: 8-bit transfer |
| phantom_ni | input | 1 | Low suppresses every memory response |
| addr_i | input | 24 | Byte address |
| lane_a_i | input | 8 | Lane A as seen from the bus (master write data) |
| lane_b_i | input | 8 | Lane B as seen from the bus (high byte of 16-bit writes) |
| lane_a_o | output | 8 | Data the board drives onto lane A |
| lane_a_oe_o | output | 1 | Lane A driver enable |
| lane_b_o | output | 8 | Data the board drives onto lane B |
| lane_b_oe_o | output | 1 | Lane B driver enable |
| bank_addr_o | output | 23 | Word address to both banks |
| bank_lo_we_o | output | 1 | Low bank write strobe |
| bank_hi_we_o | output | 1 | High bank write strobe |
| bank_lo_wdata_o | output | 8 | Low bank write data |
| bank_hi_wdata_o | output | 8 | High bank write data |
| bank_lo_rdata_i | input | 8 | Low bank read data |
| bank_hi_rdata_i | input | 8 | High bank read data |

## Verification
Every cycle, the assertions check the rules that hold in any state. Phantom suppression, one strobe at most for narrow transfers, paired strobes for wide transfers, lane enables only after a read, lane A never enabled alone, and zeroed lanes while disabled are all checked this way. Which byte lands in which bank, which bank appears on which lane, whether bit 0 is ignored in wide transfers, and whether the word address is carried intact all depend on data values. Only the directed scenarios show these, because they compare outputs against values the bench computes from the requirements.

// File: rtl/data_steer_pkg.sv
package data_steer_pkg;
  typedef struct packed {
    logic we_lo;
    logic we_hi;
    logic oe_a;
    logic oe_b;
    logic hi_sel;   // lane B takes the high bank
  } steer_ctl_t;

  localparam steer_ctl_t CTL_IDLE = '{default: 1'b0};
endpackage

// File: rtl/data_steer_decode.sv
module data_steer_decode
  import data_steer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              cyc_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic              phantom_ni,
  input  logic              addr_lsb_i,
  input  logic [BYTE_W-1:0] lane_a_i,
  input  logic [BYTE_W-1:0] lane_b_i,
  output steer_ctl_t        ctl_o,
  output logic [BYTE_W-1:0] wdata_lo_o,
  output logic [BYTE_W-1:0] wdata_hi_o
);
  logic claim, sel_lo, sel_hi;

  always_comb begin
    claim  = cyc_i & phantom_ni;
    sel_lo = wide_i | ~addr_lsb_i;
    sel_hi = wide_i |  addr_lsb_i;

    ctl_o        = CTL_IDLE;
    ctl_o.we_lo  = claim & wr_i & sel_lo;
    ctl_o.we_hi  = claim & wr_i & sel_hi;
    ctl_o.oe_b   = claim & rd_i;
    ctl_o.oe_a   = claim & rd_i & wide_i;
    ctl_o.hi_sel = sel_hi;

    wdata_lo_o = lane_a_i;
    wdata_hi_o = wide_i ? lane_b_i : lane_a_i;
  end
endmodule

// File: rtl/data_steer_stage.sv
module data_steer_stage
  import data_steer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WADDR_W = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_i,
  input  logic               wide_i,
  input  logic               phantom_ni,
  input  steer_ctl_t         ctl_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [BYTE_W-1:0]  wdata_lo_i,
  input  logic [BYTE_W-1:0]  wdata_hi_i,
  output steer_ctl_t         ctl_o,
  output logic [WADDR_W-1:0] waddr_o,
  output logic [BYTE_W-1:0]  wdata_lo_o,
  output logic [BYTE_W-1:0]  wdata_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o      <= CTL_IDLE;
      waddr_o    <= '0;
      wdata_lo_o <= '0;
      wdata_hi_o <= '0;
    end else begin
      ctl_o <= ctl_i;
      if (cyc_i) begin
        waddr_o    <= waddr_i;
        wdata_lo_o <= wdata_lo_i;
        wdata_hi_o <= wdata_hi_i;
      end
    end
  end

  assert_phantom_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cyc_i & ~phantom_ni) |-> !(ctl_o.we_lo | ctl_o.we_hi | ctl_o.oe_a | ctl_o.oe_b));

  assert_narrow_one_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cyc_i & ~wide_i) |-> !(ctl_o.we_lo & ctl_o.we_hi));

  assert_wide_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cyc_i & wide_i) |-> (ctl_o.we_lo == ctl_o.we_hi));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(~cyc_i) |-> !(ctl_o.we_lo | ctl_o.we_hi | ctl_o.oe_b));
endmodule

// File: rtl/data_steer_lane_mux.sv
module data_steer_lane_mux #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              oe_a_i,
  input  logic              oe_b_i,
  input  logic              hi_sel_i,
  input  logic [BYTE_W-1:0] rdata_lo_i,
  input  logic [BYTE_W-1:0] rdata_hi_i,
  output logic [BYTE_W-1:0] lane_a_o,
  output logic [BYTE_W-1:0] lane_b_o
);
  always_comb begin
    lane_a_o = oe_a_i ? rdata_lo_i : '0;
    lane_b_o = oe_b_i ? (hi_sel_i ? rdata_hi_i : rdata_lo_i) : '0;
  end

  always_comb begin
    assert_lane_a_idle_R11: assert (oe_a_i || lane_a_o == '0);
  end
endmodule

// File: rtl/data_steer.sv
module data_steer
  import data_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WADDR_W = ADDR_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               wide_i,
  input  logic               phantom_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  lane_a_i,
  input  logic [BYTE_W-1:0]  lane_b_i,
  output logic [BYTE_W-1:0]  lane_a_o,
  output logic               lane_a_oe_o,
  output logic [BYTE_W-1:0]  lane_b_o,
  output logic               lane_b_oe_o,
  output logic [WADDR_W-1:0] bank_addr_o,
  output logic               bank_lo_we_o,
  output logic               bank_hi_we_o,
  output logic [BYTE_W-1:0]  bank_lo_wdata_o,
  output logic [BYTE_W-1:0]  bank_hi_wdata_o,
  input  logic [BYTE_W-1:0]  bank_lo_rdata_i,
  input  logic [BYTE_W-1:0]  bank_hi_rdata_i
);
  steer_ctl_t        ctl_d, ctl_q;
  logic [BYTE_W-1:0] wd_lo_d, wd_hi_d;

  data_steer_decode #(.BYTE_W(BYTE_W)) i_decode (
    .cyc_i      (cyc_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wide_i     (wide_i),
    .phantom_ni (phantom_ni),
    .addr_lsb_i (addr_i[0]),
    .lane_a_i   (lane_a_i),
    .lane_b_i   (lane_b_i),
    .ctl_o      (ctl_d),
    .wdata_lo_o (wd_lo_d),
    .wdata_hi_o (wd_hi_d)
  );

  data_steer_stage #(.BYTE_W(BYTE_W), .WADDR_W(WADDR_W)) i_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc_i),
    .wide_i     (wide_i),
    .phantom_ni (phantom_ni),
    .ctl_i      (ctl_d),
    .waddr_i    (addr_i[ADDR_W-1:1]),
    .wdata_lo_i (wd_lo_d),
    .wdata_hi_i (wd_hi_d),
    .ctl_o      (ctl_q),
    .waddr_o    (bank_addr_o),
    .wdata_lo_o (bank_lo_wdata_o),
    .wdata_hi_o (bank_hi_wdata_o)
  );

  data_steer_lane_mux #(.BYTE_W(BYTE_W)) i_lane_mux (
    .oe_a_i     (ctl_q.oe_a),
    .oe_b_i     (ctl_q.oe_b),
    .hi_sel_i   (ctl_q.hi_sel),
    .rdata_lo_i (bank_lo_rdata_i),
    .rdata_hi_i (bank_hi_rdata_i),
    .lane_a_o   (lane_a_o),
    .lane_b_o   (lane_b_o)
  );

  assign lane_a_oe_o  = ctl_q.oe_a;
  assign lane_b_oe_o  = ctl_q.oe_b;
  assign bank_lo_we_o = ctl_q.we_lo;
  assign bank_hi_we_o = ctl_q.we_hi;

  assert_drive_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_b_oe_o |-> $past(rd_i));

  assert_lane_a_paired_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_a_oe_o |-> lane_b_oe_o);

  assert_lane_b_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_b_oe_o |-> (lane_b_o == '0));
endmodule

// File: tb/test_data_steer.sv
`timescale 1ns/1ps
module test_data_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 0, rd = 0, wr = 0, wide = 0, phn = 1;
  logic [23:0] addr = '0;
  logic [7:0]  la_i = '0, lb_i = '0;
  logic [7:0]  la_o, lb_o, wd_lo, wd_hi;
  logic        la_oe, lb_oe, we_lo, we_hi;
  logic [22:0] baddr;
  logic [7:0]  rd_lo = 8'h3C, rd_hi = 8'hA5;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  data_steer i_data_steer (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .rd_i(rd), .wr_i(wr), .wide_i(wide),
    .phantom_ni(phn), .addr_i(addr), .lane_a_i(la_i), .lane_b_i(lb_i),
    .lane_a_o(la_o), .lane_a_oe_o(la_oe), .lane_b_o(lb_o), .lane_b_oe_o(lb_oe),
    .bank_addr_o(baddr), .bank_lo_we_o(we_lo), .bank_hi_we_o(we_hi),
    .bank_lo_wdata_o(wd_lo), .bank_hi_wdata_o(wd_hi),
    .bank_lo_rdata_i(rd_lo), .bank_hi_rdata_i(rd_hi)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sampled on next posedge, result read 1 ns later
  task automatic cycle(logic v, logic r, logic w, logic wd, logic p, logic [23:0] a,
                       logic [7:0] da, logic [7:0] db);
    @(negedge clk);
    cyc = v; rd = r; wr = w; wide = wd; phn = p; addr = a; la_i = da; lb_i = db;
    @(posedge clk); #1;
  endtask

  task automatic chk_ctl(string req, logic elo, logic ehi, logic ea, logic eb);
    chk(req, "we_lo", we_lo, elo);
    chk(req, "we_hi", we_hi, ehi);
    chk(req, "oe_a", la_oe, ea);
    chk(req, "oe_b", lb_oe, eb);
  endtask

  task automatic t_reset;
    #1;
    chk_ctl("R1", 0, 0, 0, 0);
    chk("R11", "lane_b idle", lb_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_ctl("R1", 0, 0, 0, 0);
  endtask

  task automatic t_narrow_write;
    cycle(1, 0, 1, 0, 1, 24'h000010, 8'h5A, 8'hEE);
    chk_ctl("R2", 1, 0, 0, 0);
    chk("R2", "wd_lo", wd_lo, 8'h5A);
    cycle(1, 0, 1, 0, 1, 24'h000011, 8'hC3, 8'hEE);
    chk_ctl("R3", 0, 1, 0, 0);
    chk("R3", "wd_hi", wd_hi, 8'hC3);
  endtask

  task automatic t_narrow_read;
    cycle(1, 1, 0, 0, 1, 24'h000020, 8'h00, 8'h00);
    chk_ctl("R4", 0, 0, 0, 1);
    chk("R4", "lane_b even", lb_o, rd_lo);
    chk("R11", "lane_a idle", la_o, 8'h00);
    cycle(1, 1, 0, 0, 1, 24'h000021, 8'h00, 8'h00);
    chk("R4", "lane_b odd", lb_o, rd_hi);
  endtask

  task automatic t_wide;
    cycle(1, 0, 1, 1, 1, 24'h000040, 8'h12, 8'h34);
    chk_ctl("R5", 1, 1, 0, 0);
    chk("R5", "wd_lo", wd_lo, 8'h12);
    chk("R5", "wd_hi", wd_hi, 8'h34);
    cycle(1, 1, 0, 1, 1, 24'h000040, 8'h00, 8'h00);
    chk_ctl("R6", 0, 0, 1, 1);
    chk("R6", "lane_a", la_o, rd_lo);
    chk("R6", "lane_b", lb_o, rd_hi);
  endtask

  task automatic t_wide_odd;
    cycle(1, 0, 1, 1, 1, 24'h000041, 8'h56, 8'h78);
    chk_ctl("R7", 1, 1, 0, 0);
    chk("R7", "wd_lo", wd_lo, 8'h56);
    chk("R7", "wd_hi", wd_hi, 8'h78);
    chk("R7", "addr", baddr, 23'h000020);
    cycle(1, 1, 0, 1, 1, 24'h000041, 8'h00, 8'h00);
    chk("R7", "lane_a", la_o, rd_lo);
    chk("R7", "lane_b", lb_o, rd_hi);
  endtask

  task automatic t_phantom;
    cycle(1, 0, 1, 1, 0, 24'h000050, 8'h11, 8'h22);
    chk_ctl("R8", 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0, 24'h000051, 8'h00, 8'h00);
    chk_ctl("R8", 0, 0, 0, 0);
    chk("R8", "lane_b", lb_o, 8'h00);
  endtask

  task automatic t_addr;
    cycle(1, 1, 0, 0, 1, 24'hFFFFFF, 8'h00, 8'h00);
    chk("R9", "top addr", baddr, 23'h7FFFFF);
    cycle(1, 0, 1, 0, 1, 24'hA5A5A4, 8'h01, 8'h00);
    chk("R9", "mid addr", baddr, 23'h52D2D2);
  endtask

  task automatic t_mixed;
    cycle(1, 0, 1, 1, 1, 24'h000100, 8'h9A, 8'hBC);
    chk_ctl("R10", 1, 1, 0, 0);
    cycle(1, 0, 1, 0, 1, 24'h000101, 8'hDE, 8'hBC);
    chk_ctl("R10", 0, 1, 0, 0);
    chk("R10", "wd_hi narrow", wd_hi, 8'hDE);
    cycle(1, 1, 0, 0, 1, 24'h000100, 8'h00, 8'h00);
    chk_ctl("R10", 0, 0, 0, 1);
    cycle(0, 1, 1, 1, 1, 24'h000100, 8'h00, 8'h00);
    chk_ctl("R10", 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_narrow_write();
    t_narrow_read();
    t_wide();
    t_wide_odd();
    t_phantom();
    t_addr();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule